// File: doc/BRIEF.md
# Password-Gated Bank Write Lock

This unit guards the register files of up to eight GPIO banks against stray writes. It watches a simple single-cycle write bus and keeps one lock bit per bank. A bank's lock bit can change only through a two-write sequence: first the magic word goes into the global password register, then a lock code goes into that bank's lock register. While a bank is locked, the unit drops that bank's write-enable, so writes to the bank's data, control, mask and status registers are blocked.

A correct password write arms the unit for exactly one following write. Cycles with no write in them keep the unit armed. Every other write consumes or cancels the arming, whatever its address or data. Each bank's lock state can be read back at its lock register as an all-ones or all-zeros word, through a combinational read port.

Top module: `bank_wlock`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every bank is locked, every bit of `bank_wen` is 0 and the unit is not armed. A reset also cancels any arming held before it.
- R2: A write of 0x00A5A501 to the password register at byte address 0x520 arms the unit for the next write, and a repeated correct password write keeps it armed. Idle cycles do not count as writes.
- R3: When the unit is armed, a write to the lock register of bank b at byte address 0x500 + 4·b changes that bank. Data 0x00000000 unlocks it and data 0xFFFFFFFF locks it. The change takes effect at that clock edge, so `bank_wen[b]` (1 = unlocked, bank writable) changes in the following cycle. No other bank changes.
- R4: Any write that is not a correct password write disarms the unit. This includes a wrong password value, a write to an unrelated address, and any lock-register write. A lock-register write that comes after such a write has no effect.
- R5: A lock-register write while the unit is not armed leaves every bank's state unchanged.
- R6: When the unit is armed, a lock-register write whose data is neither all-zeros nor all-ones changes no bank, and it still uses up the arming.
- R7: Lock-register addresses for bank indices at or above `NBANK` behave like unrelated addresses. They change nothing, they disarm the unit, and they read back as 0.
- R8: `rd_data` returns 0xFFFFFFFF for a lock register whose bank is locked and 0x00000000 for one whose bank is unlocked. Every other address, including the password register, reads 0.
- R9: When a correct password write is followed by idle cycles, the next write still acts as an armed write.

Parameter rule: `NBANK` must lie between 1 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read-back port |
| rd_data | output | 32 | Combinational read-back data |
| bank_wen | output | NBANK | Per-bank write-enable to the bank register files, 1 = unlocked |

## Verification
The bench builds the block with `NBANK` = 6 and `ADDR_W` = 12. With six banks, the lock addresses for indices 6 and 7 still decode as lock registers in the address map but fall outside the instantiated banks. That makes the out-of-range behaviour of R7 observable, both for writes and for read-back. With a 12-bit address, the password register and every lock register can be reached.

// File: rtl/wlk_pkg.sv
`timescale 1ns/1ps
package wlk_pkg;

    localparam int MAX_BANKS = 8;
    localparam int WORD_W    = 32;
    localparam int IDX_W     = $clog2(MAX_BANKS);

    localparam logic [31:0]       PWD_OFFSET = 32'h0000_0520;
    localparam logic [31:0]       LOCK_BASE  = 32'h0000_0500;
    localparam logic [WORD_W-1:0] PWD_VALUE  = 32'h00A5_A501;
    localparam logic [WORD_W-1:0] CODE_LOCK  = '1;
    localparam logic [WORD_W-1:0] CODE_OPEN  = '0;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_PWD,
        WK_LOCKREG,
        WK_OTHER
    } wkind_e;

    typedef enum logic [1:0] {
        LC_BAD,
        LC_LOCK,
        LC_OPEN
    } lcode_e;

    typedef struct packed {
        wkind_e           kind;
        logic             pwd_ok;
        logic [IDX_W-1:0] bank;
        lcode_e           code;
    } wcls_t;

    // True when the byte address selects the lock register of a bank that exists.
    function automatic logic hits_lock(input logic [31:0] a, input int nbank);
        logic [31:0] top;
        top = LOCK_BASE + 32'(nbank * 4);
        return (a >= LOCK_BASE) && (a < top) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [IDX_W-1:0] lock_idx(input logic [31:0] a);
        logic [31:0] d;
        d = a - LOCK_BASE;
        return d[IDX_W+1:2];
    endfunction

    function automatic lcode_e classify_code(input logic [WORD_W-1:0] d);
        if (d == CODE_LOCK)      return LC_LOCK;
        else if (d == CODE_OPEN) return LC_OPEN;
        else                     return LC_BAD;
    endfunction

endpackage

// File: rtl/wlk_decode.sv
`timescale 1ns/1ps
module wlk_decode
    import wlk_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output wcls_t             cls
);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    always_comb begin
        if (!wr_en)
            cls.kind = WK_NONE;
        else if (a32 == PWD_OFFSET)
            cls.kind = WK_PWD;
        else if (hits_lock(a32, NBANK))
            cls.kind = WK_LOCKREG;
        else
            cls.kind = WK_OTHER;
        cls.pwd_ok = (data == PWD_VALUE);
        cls.bank   = lock_idx(a32);
        cls.code   = classify_code(data);
    end

endmodule

// File: rtl/wlk_arm.sv
`timescale 1ns/1ps
module wlk_arm
    import wlk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wcls_t cls,
    output logic  armed
);

    // Only a write moves the arm flag. A correct password sets it, and anything else clears it.
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (cls.kind != WK_NONE)
            armed <= (cls.kind == WK_PWD) && cls.pwd_ok;
    end

endmodule

// File: rtl/wlk_lockbank.sv
`timescale 1ns/1ps
module wlk_lockbank
    import wlk_pkg::*;
#(
    parameter int NBANK = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  wcls_t            cls,
    output logic [NBANK-1:0] locked
);

    logic take;
    assign take = armed && (cls.kind == WK_LOCKREG) && (cls.code != LC_BAD);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                locked[b] <= 1'b1;
            else if (take && (cls.bank == IDX_W'(b)))
                locked[b] <= (cls.code == LC_LOCK);
        end
    end

endmodule

// File: rtl/wlk_rdmux.sv
`timescale 1ns/1ps
module wlk_rdmux
    import wlk_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NBANK-1:0]  locked,
    output logic [WORD_W-1:0] rd_data
);

    logic [31:0]          a32;
    logic [MAX_BANKS-1:0] lk_pad;

    assign a32    = 32'(rd_addr);
    assign lk_pad = MAX_BANKS'(locked);

    always_comb begin
        if (hits_lock(a32, NBANK))
            rd_data = {WORD_W{lk_pad[lock_idx(a32)]}};
        else
            rd_data = '0;
    end

endmodule

// File: rtl/bank_wlock.sv
`timescale 1ns/1ps
module bank_wlock
    import wlk_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [NBANK-1:0]  bank_wen
);

    if (NBANK < 1 || NBANK > MAX_BANKS) begin : g_bad_nbank
        $error("bank_wlock: NBANK out of range");
    end

    wcls_t            cls;
    logic             armed_q;
    logic [NBANK-1:0] locked;

    wlk_decode #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_decode (
        .wr_en (wr_en),
        .addr  (wr_addr),
        .data  (wr_data),
        .cls   (cls)
    );

    wlk_arm i_arm (
        .clk   (clk),
        .rst   (rst),
        .cls   (cls),
        .armed (armed_q)
    );

    wlk_lockbank #(.NBANK(NBANK)) i_lockbank (
        .clk    (clk),
        .rst    (rst),
        .armed  (armed_q),
        .cls    (cls),
        .locked (locked)
    );

    wlk_rdmux #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_rdmux (
        .rd_addr (rd_addr),
        .locked  (locked),
        .rd_data (rd_data)
    );

    assign bank_wen = ~locked;

endmodule

// File: rtl/wlk_checker.sv
`timescale 1ns/1ps
module wlk_checker
    import wlk_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic [NBANK-1:0]  bank_wen,
    input logic              armed
);

    logic is_pwd_addr, is_lock_addr, bad_code;
    assign is_pwd_addr  = (32'(wr_addr) == PWD_OFFSET);
    assign is_lock_addr = hits_lock(32'(wr_addr), NBANK);
    assign bad_code     = (wr_data != '0) && (wr_data != '1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (bank_wen == '0) && !armed);

    assert_pwd_arms_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_pwd_addr && wr_data == PWD_VALUE) |=> armed);

    assert_one_bank_moves_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones(bank_wen ^ $past(bank_wen)) <= 1));

    assert_nonpwd_disarms_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_pwd_addr) |=> !armed);

    assert_unarmed_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(bank_wen));

    assert_bad_code_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_lock_addr && bad_code) |=> $stable(bank_wen));

    assert_readback_word_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_data == '0) || (rd_data == '1));

endmodule

bind bank_wlock wlk_checker #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_wlk_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .bank_wen (bank_wen),
    .armed    (armed_q)
);

// File: tb/test_bank_wlock.sv
`timescale 1ns/1ps
module test_bank_wlock;

    localparam int NB = 6;
    localparam int AW = 12;
    localparam logic [31:0] PWD = 32'h00A5_A501;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NB-1:0] bank_wen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bank_wlock #(.NBANK(NB), .ADDR_W(AW)) i_bank_wlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .bank_wen (bank_wen)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the capturing rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // {req, addr, data, expected bank_wen after the write}
    localparam logic [53:0] VEC [23] = '{
        {4'd2, 12'h520, 32'h00A5A501, 6'b000000},  // R2 arm
        {4'd3, 12'h508, 32'h00000000, 6'b000100},  // R3 unlock bank 2
        {4'd2, 12'h520, 32'h00A5A501, 6'b000100},  // R2
        {4'd3, 12'h500, 32'h00000000, 6'b000101},  // R3 unlock bank 0
        {4'd5, 12'h508, 32'hFFFFFFFF, 6'b000101},  // R5 unarmed lock write
        {4'd4, 12'h520, 32'h00A5A500, 6'b000101},  // R4 wrong password
        {4'd4, 12'h50C, 32'h00000000, 6'b000101},  // R4 not armed after it
        {4'd2, 12'h520, 32'h00A5A501, 6'b000101},  // R2
        {4'd4, 12'h040, 32'h00000000, 6'b000101},  // R4 unrelated write
        {4'd4, 12'h510, 32'h00000000, 6'b000101},  // R4 disarmed
        {4'd2, 12'h520, 32'h00A5A501, 6'b000101},  // R2
        {4'd6, 12'h514, 32'h12345678, 6'b000101},  // R6 bad code
        {4'd6, 12'h514, 32'h00000000, 6'b000101},  // R6 arming used up
        {4'd2, 12'h520, 32'h00A5A501, 6'b000101},  // R2
        {4'd3, 12'h508, 32'hFFFFFFFF, 6'b000001},  // R3 relock bank 2
        {4'd2, 12'h520, 32'h00A5A501, 6'b000001},  // R2
        {4'd7, 12'h518, 32'h00000000, 6'b000001},  // R7 bank 6 absent
        {4'd7, 12'h51C, 32'h00000000, 6'b000001},  // R7 disarmed by it
        {4'd2, 12'h520, 32'h00A5A501, 6'b000001},  // R2
        {4'd2, 12'h520, 32'h00A5A501, 6'b000001},  // R2 repeated password
        {4'd2, 12'h514, 32'h00000000, 6'b100001},  // R2 still armed: bank 5
        {4'd2, 12'h520, 32'h00A5A501, 6'b100001},  // R2
        {4'd3, 12'h504, 32'h00000000, 6'b100011}   // R3 unlock bank 1
    };

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 bank_wen after reset", 32'(bank_wen), 32'h0);
        for (int b = 0; b < NB; b++)
            rd_check("R8 locked readback after reset", AW'(12'h500 + 4 * b), 32'hFFFFFFFF);

        for (int i = 0; i < 23; i++) begin
            wr(VEC[i][49:38], VEC[i][37:6]);
            check($sformatf("R%0d vector %0d", VEC[i][53:50], i), 32'(bank_wen), 32'(VEC[i][5:0]));
        end

        // R8 readback of the mixed state 100011
        for (int b = 0; b < NB; b++)
            rd_check("R8 lock readback", AW'(12'h500 + 4 * b),
                     ((6'b100011 >> b) & 6'b1) != 0 ? 32'h0 : 32'hFFFFFFFF);
        rd_check("R8 password reads zero", 12'h520, 32'h0);
        rd_check("R7 absent bank reads zero", 12'h518, 32'h0);

        // R9 idle cycles keep the arming
        wr(12'h520, PWD);
        repeat (5) @(negedge clk);
        wr(12'h504, 32'hFFFFFFFF);
        check("R9 armed across idle cycles", 32'(bank_wen), 32'h21);

        // R3 timing: no change before the capturing edge
        wr(12'h520, PWD);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h50C; wr_data = 32'h0;
        #1;
        check("R3 unchanged before edge", 32'(bank_wen), 32'h21);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 changed after edge", 32'(bank_wen), 32'h29);

        // R1 reset clears arming and relocks every bank
        wr(12'h520, PWD);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 relocked by reset", 32'(bank_wen), 32'h0);
        wr(12'h500, 32'h0);
        check("R1 arming cleared by reset", 32'(bank_wen), 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule